// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block gives a keep-or-discard decision for each received Ethernet frame. It watches a byte stream that carries start, valid and end strobes. From the first six bytes it builds the 48-bit destination address. When the end strobe arrives it reads the final frame length. It compares the address against one station address and a table of alias addresses. It also applies four control bits: promiscuous, broadcast reject, short-frame enable and alias enable.

One clock after the end strobe the block gives a one-cycle verdict. The verdict carries an accept bit and a miss bit. The miss bit marks a frame that was kept even though its address did not truly match. Later receive logic uses the verdict to either commit or discard the buffered frame.

The control bits and the address registers are captured when the frame starts. A write to them in the middle of a frame therefore affects only later frames.

Top module: `eth_da_filter`

## Requirements
- R1: `vd_valid` is high for exactly one cycle, in the cycle after each cycle where `rx_eof` is high, and is low otherwise.
- R2: The destination address is the first six valid bytes of the frame, with the first byte in bits 47:40. A frame of 64 bytes or more whose address equals `station_mac` is accepted with miss clear.
- R3: With promiscuous clear, a frame of 64 bytes or more is dropped when its address matches neither the station address nor an enabled alias entry, and is not a broadcast accepted under R5.
- R4: With promiscuous set, every frame of 64 bytes or more is accepted. Miss is set when no station, alias or accepted-broadcast match exists.
- R5: A frame to FF:FF:FF:FF:FF:FF with broadcast reject clear counts as an address match. If it is 64 bytes or more, it is accepted with miss clear.
- R6: A broadcast frame is dropped when broadcast reject is set and promiscuous is clear.
- R7: A broadcast frame of 64 bytes or more, with broadcast reject and promiscuous both set, is accepted with miss set.
- R8: With short-frame enable clear, every frame shorter than 64 bytes is dropped.
- R9: With short-frame enable set, a frame of 17 to 63 bytes is accepted, with miss clear, only on a station, alias or accepted-broadcast match. Promiscuous mode alone does not keep it.
- R10: A frame of 16 bytes or fewer is always dropped, whatever the control bits are.
- R11: With alias enable set, an address equal to alias entry k (bits 48k+47 down to 48k of `alias_macs`, k = 0 to 14) counts as a match.
- R12: With alias enable clear, the alias entries never produce a match.
- R13: Control bits, `station_mac` and `alias_macs` are sampled in the `rx_sof` cycle. Changes later in the frame do not affect that frame's verdict.
- R14: Miss is never set on a dropped frame, nor on a frame that had a real address match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | First byte of a frame; high together with rx_valid |
| rx_valid | input | 1 | rx_data holds a frame byte |
| rx_data | input | 8 | Frame byte |
| rx_eof | input | 1 | Last byte of a frame; high together with rx_valid |
| rx_len | input | 16 | Frame length in bytes, sampled while rx_eof is high |
| ctl_promisc | input | 1 | Promiscuous mode |
| ctl_bcast_reject | input | 1 | Broadcast reject |
| ctl_short_ok | input | 1 | Short-frame enable |
| ctl_alias_en | input | 1 | Alias table enable |
| station_mac | input | 48 | Station address |
| alias_macs | input | 720 | Fifteen alias addresses; entry k in bits 48k+47:48k |
| vd_valid | output | 1 | Verdict pulse |
| vd_accept | output | 1 | Frame kept |
| vd_miss | output | 1 | Frame kept without a real address match |

## Verification
The assertions take some facts about the input stream for granted:
- Every frame opens with one `rx_sof` and closes with one `rx_eof`, and both coincide with `rx_valid`.
- Frames do not overlap.
- `rx_len` is stable and meaningful whenever `rx_eof` is high.

The bench keeps to these rules. It sends each frame as a contiguous run of bytes, with `rx_len` equal to the number of bytes sent. Frames are sent back to back or with idle gaps. Mid-frame writes to the control and address inputs happen only between the start and end strobes of a frame.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam int MAC_W      = 48;
    localparam int DA_BYTES   = 6;
    localparam int LEN_W      = 16;
    localparam int MIN_FRAME  = 64;
    localparam int RUNT_LIMIT = 16;
    localparam int CNT_W      = $clog2(DA_BYTES + 1);

    typedef logic [MAC_W-1:0] mac_t;

    localparam mac_t BCAST_MAC = '1;

    typedef struct packed {
        logic prom;
        logic bc_rej;
        logic short_en;
        logic alias_en;
    } filt_cfg_t;

    typedef struct packed {
        logic station_hit;
        logic alias_hit;
        logic bcast;
    } match_t;

    typedef struct packed {
        logic accept;
        logic miss;
    } verdict_t;

    // Final decision from the length, the match flags and the frame's captured controls.
    function automatic verdict_t judge(input logic [LEN_W-1:0] len,
                                       input match_t m,
                                       input filt_cfg_t c);
        logic     addr_ok;
        verdict_t v;
        addr_ok = m.station_hit | m.alias_hit | (m.bcast & ~c.bc_rej);
        v = '0;
        if (len <= LEN_W'(RUNT_LIMIT)) begin
            v = '0;
        end else if (len < LEN_W'(MIN_FRAME)) begin
            v.accept = c.short_en & addr_ok;
        end else begin
            v.accept = addr_ok | c.prom;
            v.miss   = ~addr_ok & c.prom;
        end
        return v;
    endfunction

endpackage

// File: rtl/da_capture.sv
module da_capture
    import daf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sof,
    input  logic       valid,
    input  logic [7:0] data,
    output mac_t       da_now
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DA_BYTES);

    mac_t             da_q, da_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        da_n  = da_q;
        cnt_n = cnt_q;
        if (valid && sof) begin
            da_n  = {{(MAC_W-8){1'b0}}, data};
            cnt_n = CNT_W'(1);
        end else if (valid && cnt_q < FULL) begin
            da_n  = {da_q[MAC_W-9:0], data};
            cnt_n = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            da_q  <= '0;
            cnt_q <= FULL;
        end else begin
            da_q  <= da_n;
            cnt_q <= cnt_n;
        end
    end

    // The address includes the byte that arrives in the current cycle.
    assign da_now = da_n;

    assert_count_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

endmodule

// File: rtl/cfg_snapshot.sv
module cfg_snapshot
    import daf_pkg::*;
#(
    parameter int NUM_ALIAS = 15
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sof,
    input  filt_cfg_t                  cfg_live,
    input  mac_t                       station_live,
    input  logic [NUM_ALIAS*MAC_W-1:0] alias_live,
    output filt_cfg_t                  cfg_now,
    output mac_t                       station_now,
    output logic [NUM_ALIAS*MAC_W-1:0] alias_now
);
    filt_cfg_t                  cfg_q;
    mac_t                       station_q;
    logic [NUM_ALIAS*MAC_W-1:0] alias_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            station_q <= '0;
            alias_q   <= '0;
        end else if (sof) begin
            cfg_q     <= cfg_live;
            station_q <= station_live;
            alias_q   <= alias_live;
        end
    end

    // In the start cycle the live values apply; after it, the held copy.
    assign cfg_now     = sof ? cfg_live     : cfg_q;
    assign station_now = sof ? station_live : station_q;
    assign alias_now   = sof ? alias_live   : alias_q;

endmodule

// File: rtl/addr_match.sv
module addr_match
    import daf_pkg::*;
#(
    parameter int NUM_ALIAS = 15
) (
    input  mac_t                       da,
    input  mac_t                       station,
    input  logic [NUM_ALIAS*MAC_W-1:0] alias_tab,
    input  logic                       alias_en,
    output match_t                     hit
);
    logic [NUM_ALIAS-1:0] entry_eq;

    for (genvar k = 0; k < NUM_ALIAS; k++) begin : g_alias
        assign entry_eq[k] = (alias_tab[k*MAC_W +: MAC_W] == da);
    end

    always_comb begin
        hit.station_hit = (da == station);
        hit.alias_hit   = alias_en & (|entry_eq);
        hit.bcast       = (da == BCAST_MAC);
    end

endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
    import daf_pkg::*;
#(
    parameter int NUM_ALIAS = 15,
    localparam int ALIAS_BITS = NUM_ALIAS * MAC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_sof,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_eof,
    input  logic [LEN_W-1:0]      rx_len,
    input  logic                  ctl_promisc,
    input  logic                  ctl_bcast_reject,
    input  logic                  ctl_short_ok,
    input  logic                  ctl_alias_en,
    input  logic [MAC_W-1:0]      station_mac,
    input  logic [ALIAS_BITS-1:0] alias_macs,
    output logic                  vd_valid,
    output logic                  vd_accept,
    output logic                  vd_miss
);
    filt_cfg_t             cfg_live, cfg_now;
    mac_t                  da_now, station_now;
    logic [ALIAS_BITS-1:0] alias_now;
    match_t                match_now;
    verdict_t              vd_n, vd_q;
    logic                  vd_valid_q;

    always_comb begin
        cfg_live.prom     = ctl_promisc;
        cfg_live.bc_rej   = ctl_bcast_reject;
        cfg_live.short_en = ctl_short_ok;
        cfg_live.alias_en = ctl_alias_en;
    end

    da_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .sof    (rx_sof),
        .valid  (rx_valid),
        .data   (rx_data),
        .da_now (da_now)
    );

    cfg_snapshot #(.NUM_ALIAS(NUM_ALIAS)) u_snap (
        .clk          (clk),
        .rst          (rst),
        .sof          (rx_sof),
        .cfg_live     (cfg_live),
        .station_live (station_mac),
        .alias_live   (alias_macs),
        .cfg_now      (cfg_now),
        .station_now  (station_now),
        .alias_now    (alias_now)
    );

    addr_match #(.NUM_ALIAS(NUM_ALIAS)) u_match (
        .da        (da_now),
        .station   (station_now),
        .alias_tab (alias_now),
        .alias_en  (cfg_now.alias_en),
        .hit       (match_now)
    );

    assign vd_n = judge(rx_len, match_now, cfg_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            vd_valid_q <= 1'b0;
            vd_q       <= '0;
        end else begin
            vd_valid_q <= rx_eof;
            vd_q       <= rx_eof ? vd_n : '0;
        end
    end

    assign vd_valid  = vd_valid_q;
    assign vd_accept = vd_q.accept;
    assign vd_miss   = vd_q.miss;

    assert_verdict_after_eof_R1: assert property (@(posedge clk) disable iff (rst)
        vd_valid |-> $past(rx_eof));

    assert_miss_needs_accept_R14: assert property (@(posedge clk) disable iff (rst)
        vd_miss |-> (vd_valid && vd_accept));

    assert_runt_dropped_R10: assert property (@(posedge clk) disable iff (rst)
        (vd_valid && vd_accept) |-> ($past(rx_len) > LEN_W'(RUNT_LIMIT)));

    assert_bcast_reject_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_eof && match_now.bcast && cfg_now.bc_rej && !cfg_now.prom) |=> !vd_accept);

    assert_short_needs_match_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_eof && rx_len < LEN_W'(MIN_FRAME)
         && !match_now.station_hit && !match_now.alias_hit && !match_now.bcast) |=> !vd_accept);

endmodule

// File: tb/eth_da_filter_bench.sv
`timescale 1ns/1ps
module eth_da_filter_bench;
    localparam int NA = 15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rx_sof = 0, rx_valid = 0, rx_eof = 0;
    logic [7:0]   rx_data = '0;
    logic [15:0]  rx_len = '0;
    logic         ctl_promisc = 0, ctl_bcast_reject = 0, ctl_short_ok = 0, ctl_alias_en = 0;
    logic [47:0]  station_mac = 48'h0200_1234_5678;
    logic [NA*48-1:0] alias_macs;
    logic         vd_valid, vd_accept, vd_miss;

    int errors = 0;
    int checks = 0;
    bit exp_acc_q[$];
    bit exp_miss_q[$];
    string exp_tag_q[$];
    logic [31:0] lfsr = 32'hACE1_2357;

    always #2.5 clk = ~clk;

    eth_da_filter u_eth_da_filter (
        .clk(clk), .rst(rst), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eof(rx_eof), .rx_len(rx_len), .ctl_promisc(ctl_promisc),
        .ctl_bcast_reject(ctl_bcast_reject), .ctl_short_ok(ctl_short_ok),
        .ctl_alias_en(ctl_alias_en), .station_mac(station_mac), .alias_macs(alias_macs),
        .vd_valid(vd_valid), .vd_accept(vd_accept), .vd_miss(vd_miss)
    );

    function automatic logic [47:0] alias_of(input int k);
        return 48'h0600_AB00_0000 | 48'(k * 37 + 5);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: a verdict written directly from the requirement text.
    task automatic expect_verdict(input logic [47:0] da, input int len, input bit p,
                                  input bit br, input bit se, input bit ae,
                                  input logic [47:0] st, input logic [NA*48-1:0] tab,
                                  input string tag);
        bit matched = 0;
        bit acc = 0;
        bit ms = 0;
        if (da == st) matched = 1;
        if (ae) for (int k = 0; k < NA; k++) if (tab[k*48 +: 48] == da) matched = 1;
        if (da == '1 && !br) matched = 1;
        if (len <= 16) begin
            acc = 0;
        end else if (len < 64) begin
            acc = se && matched;
        end else if (matched) begin
            acc = 1;
        end else if (p) begin
            acc = 1;
            ms = 1;
        end
        exp_acc_q.push_back(acc);
        exp_miss_q.push_back(ms);
        exp_tag_q.push_back(tag);
    endtask

    // Sends one frame. With mid set, every live control and address input is changed
    // after the start byte (R13).
    task automatic send_frame(input logic [47:0] da, input int len, input bit p, input bit br,
                              input bit se, input bit ae, input bit mid, input int gap,
                              input string tag);
        logic [47:0]      st0 = station_mac;
        logic [NA*48-1:0] tab0 = alias_macs;
        @(negedge clk);
        ctl_promisc = p; ctl_bcast_reject = br; ctl_short_ok = se; ctl_alias_en = ae;
        expect_verdict(da, len, p, br, se, ae, st0, tab0, tag);
        for (int i = 0; i < len; i++) begin
            if (i > 0) @(negedge clk);
            rx_valid = 1;
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_len   = rx_eof ? 16'(len) : 16'h0;
            rx_data  = (i < 6) ? da[47 - 8*i -: 8] : 8'(i);
            if (mid && i == 2) begin
                ctl_promisc = !p; ctl_bcast_reject = !br; ctl_short_ok = !se; ctl_alias_en = !ae;
                station_mac = ~st0;
                alias_macs  = ~tab0;
            end
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_len = '0; rx_data = '0;
        station_mac = st0;
        alias_macs  = tab0;
        repeat (gap) @(negedge clk);
    endtask

    // Per-cycle comparison against the model (R1 timing and the verdict contents).
    initial begin
        forever begin
            bit ev;
            @(posedge clk);
            ev = rx_eof && !rst;
            #1;
            if (!rst) begin
                check("R1 verdict pulse", 32'(vd_valid), 32'(ev));
                if (ev && exp_acc_q.size() > 0) begin
                    string t = exp_tag_q.pop_front();
                    check({t, " accept"}, 32'(vd_accept), 32'(exp_acc_q.pop_front()));
                    check({t, " miss R14"}, 32'(vd_miss), 32'(exp_miss_q.pop_front()));
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [47:0] other = 48'h0200_DEAD_BEEF;
        logic [47:0] mcast = 48'h0100_5E00_0001;
        for (int k = 0; k < NA; k++) alias_macs[k*48 +: 48] = alias_of(k);
        repeat (4) @(negedge clk);
        check("reset vd_valid", 32'(vd_valid), 0);
        check("reset vd_accept", 32'(vd_accept), 0);
        check("reset vd_miss", 32'(vd_miss), 0);
        rst = 0;
        @(negedge clk);
        send_frame(station_mac, 64, 0,0,0,0, 0, 0, "R2 station 64");
        send_frame(station_mac, 1518, 0,0,0,0, 0, 2, "R2 station 1518");
        send_frame(other, 64, 0,0,0,0, 0, 0, "R3 unknown dropped");
        send_frame(mcast, 80, 0,0,0,1, 0, 1, "R3 multicast dropped");
        send_frame(other, 64, 1,0,0,0, 0, 0, "R4 promisc miss");
        send_frame(station_mac, 70, 1,0,0,0, 0, 0, "R4 promisc real match");
        send_frame('1, 64, 0,0,0,0, 0, 0, "R5 bcast accepted");
        send_frame('1, 64, 0,1,0,0, 0, 0, "R6 bcast rejected");
        send_frame('1, 90, 1,1,0,0, 0, 0, "R7 bcast rej+promisc");
        send_frame(station_mac, 63, 1,0,0,0, 0, 0, "R8 short disabled");
        send_frame(station_mac, 17, 0,0,1,0, 0, 0, "R9 short 17 match");
        send_frame(station_mac, 63, 0,0,1,0, 0, 0, "R9 short 63 match");
        send_frame(other, 40, 1,0,1,0, 0, 0, "R9 short promisc no match");
        send_frame('1, 30, 0,0,1,0, 0, 0, "R9 short bcast");
        send_frame(station_mac, 16, 1,0,1,1, 0, 0, "R10 runt 16");
        send_frame(station_mac, 3, 1,0,1,1, 0, 1, "R10 runt 3");
        send_frame(alias_of(0), 64, 0,0,0,1, 0, 0, "R11 alias 0");
        send_frame(alias_of(7), 64, 0,0,0,1, 0, 0, "R11 alias 7");
        send_frame(alias_of(14), 20, 0,0,1,1, 0, 0, "R11 alias 14 short");
        send_frame(alias_of(7), 64, 0,0,0,0, 0, 0, "R12 alias disabled");
        send_frame(alias_of(3), 64, 1,0,0,0, 0, 0, "R12 alias disabled promisc");
        send_frame(other, 64, 0,0,0,0, 1, 0, "R13 promisc set mid-frame");
        send_frame(station_mac, 64, 0,0,0,0, 1, 0, "R13 station moved mid-frame");
        send_frame(alias_of(5), 30, 0,0,1,1, 1, 0, "R13 alias/short mid-frame");
        for (int n = 0; n < 60; n++) begin
            logic [47:0] d;
            int len;
            int sel;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            sel = int'(lfsr[2:0]);
            case (sel)
                0, 1: d = station_mac;
                2, 3: d = alias_of(int'(lfsr[11:8]) % NA);
                4:    d = '1;
                5:    d = mcast;
                default: d = other ^ 48'(lfsr[15:8]);
            endcase
            case (lfsr[18:16])
                3'd0: len = 10; 3'd1: len = 16; 3'd2: len = 17; 3'd3: len = 45;
                3'd4: len = 63; 3'd5: len = 64; 3'd6: len = 65; default: len = 100;
            endcase
            send_frame(d, len, lfsr[20], lfsr[21], lfsr[22], lfsr[23], lfsr[24],
                       int'(lfsr[26:25]), "R2-mix random frame");
        end
        repeat (4) @(negedge clk);
        check("R1 all verdicts seen", 32'(exp_acc_q.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule